// File: doc/BRIEF.md
# Optimal-Filter Energy and Timing Unit

This unit reconstructs the energy, the timing and a pulse-quality (chi-square) figure of a calorimeter pulse for one triggered event. Each event is five digitised samples of one channel, together with that channel's pedestal. The five samples are corrected by the pedestal and then weighted by per-channel optimal-filter coefficients. Every channel owns three sets of five signed coefficients: energy weights `a`, timing weights `b` and pulse-shape values `g`. A write port loads these sets at run time.

All arithmetic runs on one 18x18 signed multiplier and its accumulator, one product per clock, under a sequencer. The unit accepts a new event only while it is idle. It always forms the energy. It goes on to form timing and chi-square only when the energy is strictly above a programmable threshold. Otherwise it reports zeros for those two values and raises a below-threshold flag.

The sequencer has the states IDLE, ENERGY, CHECK, TIMING, QSHAPE, QSQUARE and FINISH, with these transitions:
- IDLE to ENERGY, when an event is accepted.
- ENERGY to ENERGY for the first four steps, then ENERGY to CHECK after the fifth.
- CHECK to TIMING when the energy is above the threshold. CHECK to FINISH otherwise.
- TIMING to QSHAPE after five steps.
- QSHAPE always goes to QSQUARE.
- QSQUARE goes back to QSHAPE, or to FINISH after the fifth sample.
- FINISH always goes to IDLE.

Top module: `ofc_energy_unit`

## Requirements
- R1: After reset, `ev_ready` is 1 and `res_valid` is 0, and every coefficient of every channel is zero.
- R2: A corrected sample is d_i = sat(s_i − pedestal). Here sat clamps a value to the 18-bit signed range [−131072, 131071]. `ev_samples` holds sample i (i = 0..4) in bits [16i+15:16i], and each sample is a signed 16-bit value. The reported energy is E = (Σ a_i·d_i) >>> 8, an arithmetic shift that rounds toward minus infinity.
- R3: Timing and chi-square are formed only when E > `energy_thr` (a signed compare). When E equals the threshold or is below it, `res_timing` and `res_chi` are 0 and `res_below` is 1. Otherwise `res_below` is 0.
- R4: Above threshold, the timing value is T = (Σ b_i·d_i) >>> 8.
- R5: Above threshold, the chi-square is Σ r_i², where r_i = sat(d_i − ((sat(E)·g_i) >>> 8)). The chi-square is never negative.
- R6: A write with `cfg_we` set stores `cfg_data` into coefficient `cfg_sel` of channel `cfg_chan`. Selector values 0–4 address a_0..a_4, 5–9 address b_0..b_4 and 10–14 address g_0..g_4. Selector value 15 changes nothing. An event uses the set of its own channel, and the result echoes the channel number in `res_chan`.
- R7: The coefficient set is captured at the clock edge that accepts the event. A write in that cycle or during the computation does not affect the event, and it does take effect for the next event.
- R8: An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both 1, and `ev_ready` is 0 from then until the result is out. For an event below threshold, `res_valid` is 1 in the 7th cycle after the accepting edge. For an event above threshold, it is 1 in the 22nd cycle.
- R9: `res_valid` is a one-cycle pulse, issued once for each accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_chan | input | 3 | Channel of the coefficient write |
| cfg_sel | input | 4 | Coefficient selector (0–4 a, 5–9 b, 10–14 g) |
| cfg_data | input | 18 | Signed coefficient value |
| energy_thr | input | 31 | Signed energy threshold |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Unit idle, so an event can be accepted |
| ev_chan | input | 3 | Channel of the event |
| ev_samples | input | 80 | Five signed 16-bit samples |
| ev_ped | input | 16 | Signed pedestal |
| res_valid | output | 1 | Result pulse |
| res_chan | output | 3 | Channel of the result |
| res_energy | output | 31 | Signed energy |
| res_timing | output | 31 | Signed timing sum |
| res_chi | output | 39 | Chi-square |
| res_below | output | 1 | Energy not above threshold |

## Verification
On every cycle, the assertions check the following:
- the result pulse lasts one cycle;
- `ev_ready` falls after an acceptance;
- a below-threshold result carries zero timing and zero chi-square;
- the chi-square is never negative;
- the captured coefficient set stays frozen while the sequencer is busy;
- the sample step counter stays within the five samples.

Only the bench scenarios can show the rest. These are the arithmetic values against an independent model, the strict threshold compare at exact equality, the clamping of the residual and of the energy operand, the choice of the channel's coefficient set, that selector 15 is ignored, that a write during an event is held back until the next event, and the exact latency of both paths.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    localparam int NSAMP = 5;
    localparam int NSET  = 3;
    localparam int NCOEF = NSAMP * NSET;
    localparam int SELW  = 4;
    localparam int MW    = 18;
    localparam int PW    = 2 * MW;
    localparam int AW    = PW + 3;

    typedef logic signed [MW-1:0] op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENERGY,
        S_CHECK,
        S_TIMING,
        S_QSHAPE,
        S_QSQUARE,
        S_FINISH
    } seq_state_e;

    // clamp a wide signed value into the multiplier operand range
    function automatic op_t sat_op(input logic signed [PW:0] v);
        logic signed [PW:0] hi;
        logic signed [PW:0] lo;
        hi = '0;
        hi[MW-2:0] = '1;
        lo = '1;
        lo[MW-2:0] = '0;
        if (v > hi)
            return hi[MW-1:0];
        else if (v < lo)
            return lo[MW-1:0];
        else
            return v[MW-1:0];
    endfunction

endpackage

// File: rtl/ofc_coef_bank.sv
module ofc_coef_bank
    import ofc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CHW-1:0]        wr_chan,
    input  logic [SELW-1:0]       wr_sel,
    input  op_t                   wr_data,
    input  logic [CHW-1:0]        rd_chan,
    output logic [NCOEF*MW-1:0]   rd_row
);

    logic [NCOEF*MW-1:0] rows [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [NCOEF*MW-1:0] row_q;
        logic                hit;

        assign hit = wr_en && (int'(wr_chan) == c) && (int'(wr_sel) < NCOEF);

        always_ff @(posedge clk) begin
            if (rst)
                row_q <= '0;
            else if (hit)
                row_q[int'(wr_sel)*MW +: MW] <= wr_data;
        end

        assign rows[c] = row_q;
    end

    assign rd_row = rows[rd_chan];

endmodule

// File: rtl/ofc_mac.sv
module ofc_mac
    import ofc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 acc_en,
    input  op_t                  op_x,
    input  op_t                  op_y,
    output logic signed [PW-1:0] prod,
    output logic signed [AW-1:0] sum_nxt
);

    logic signed [PW-1:0] x_w;
    logic signed [PW-1:0] y_w;
    logic signed [AW-1:0] acc_q;

    assign x_w     = PW'(op_x);
    assign y_w     = PW'(op_y);
    assign prod    = x_w * y_w;
    assign sum_nxt = acc_q + $signed({{(AW-PW){prod[PW-1]}}, prod});

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (acc_en)
            acc_q <= sum_nxt;
    end

endmodule

// File: rtl/ofc_seq.sv
module ofc_seq
    import ofc_pkg::*;
#(
    parameter int SW   = 16,
    parameter int FRAC = 8,
    parameter int CHW  = 3,
    parameter int EW   = AW - FRAC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ev_valid,
    input  logic [CHW-1:0]        ev_chan,
    input  logic [NSAMP*SW-1:0]   ev_samples,
    input  logic [SW-1:0]         ev_ped,
    input  logic signed [EW-1:0]  energy_thr,
    input  logic [NCOEF*MW-1:0]   coef_row,
    input  logic signed [PW-1:0]  mac_prod,
    input  logic signed [AW-1:0]  mac_sum,
    output logic                  mac_clr,
    output logic                  mac_en,
    output op_t                   mac_x,
    output op_t                   mac_y,
    output logic                  ev_ready,
    output logic                  res_valid,
    output logic [CHW-1:0]        res_chan,
    output logic signed [EW-1:0]  res_energy,
    output logic signed [EW-1:0]  res_timing,
    output logic [AW-1:0]         res_chi,
    output logic                  res_below
);

    localparam logic [2:0] LAST = 3'(NSAMP - 1);

    seq_state_e           state_q, state_d;
    logic [2:0]           k_q;
    logic [NCOEF*MW-1:0]  cset_q;
    op_t                  d_q [NSAMP];
    op_t                  d_new [NSAMP];
    op_t                  r_q;
    logic [CHW-1:0]       chan_q;
    logic signed [EW-1:0] e_q;
    logic signed [EW-1:0] t_q;
    logic [AW-1:0]        chi_q;
    logic                 below_q;
    logic                 accept;
    logic                 last_step;
    logic signed [PW:0]   shp_w;
    logic signed [PW:0]   resid_w;

    // pedestal correction for every sample of the incoming event
    for (genvar i = 0; i < NSAMP; i++) begin : g_corr
        logic signed [SW:0] diff_w;
        assign diff_w = $signed({ev_samples[i*SW+SW-1], ev_samples[i*SW +: SW]})
                      - $signed({ev_ped[SW-1], ev_ped});
        assign d_new[i] = sat_op((PW+1)'(diff_w));
    end

    assign accept    = ev_valid && (state_q == S_IDLE);
    assign last_step = (k_q == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_ENERGY;
            S_ENERGY:  if (last_step) state_d = S_CHECK;
            S_CHECK:   state_d = (e_q > energy_thr) ? S_TIMING : S_FINISH;
            S_TIMING:  if (last_step) state_d = S_QSHAPE;
            S_QSHAPE:  state_d = S_QSQUARE;
            S_QSQUARE: state_d = last_step ? S_FINISH : S_QSHAPE;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // multiplier operand selection and accumulator control
    always_comb begin
        mac_x    = '0;
        mac_y    = '0;
        mac_en   = 1'b0;
        mac_clr  = 1'b0;
        ev_ready = (state_q == S_IDLE);
        unique case (state_q)
            S_IDLE: mac_clr = accept;
            S_ENERGY: begin
                mac_x  = cset_q[int'(k_q)*MW +: MW];
                mac_y  = d_q[k_q];
                mac_en = 1'b1;
            end
            S_CHECK: mac_clr = 1'b1;
            S_TIMING: begin
                mac_x   = cset_q[(NSAMP + int'(k_q))*MW +: MW];
                mac_y   = d_q[k_q];
                mac_en  = 1'b1;
                mac_clr = last_step;
            end
            S_QSHAPE: begin
                mac_x = sat_op((PW+1)'(e_q));
                mac_y = cset_q[(2*NSAMP + int'(k_q))*MW +: MW];
            end
            S_QSQUARE: begin
                mac_x  = r_q;
                mac_y  = r_q;
                mac_en = 1'b1;
            end
            S_FINISH: ;
            default: ;
        endcase
    end

    assign shp_w   = (PW+1)'(mac_prod >>> FRAC);
    assign resid_w = (PW+1)'(d_q[k_q]) - shp_w;

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            k_q        <= '0;
            cset_q     <= '0;
            r_q        <= '0;
            chan_q     <= '0;
            e_q        <= '0;
            t_q        <= '0;
            chi_q      <= '0;
            below_q    <= 1'b0;
            res_valid  <= 1'b0;
            res_chan   <= '0;
            res_energy <= '0;
            res_timing <= '0;
            res_chi    <= '0;
            res_below  <= 1'b0;
            for (int i = 0; i < NSAMP; i++) d_q[i] <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        k_q    <= '0;
                        cset_q <= coef_row;
                        chan_q <= ev_chan;
                        for (int i = 0; i < NSAMP; i++) d_q[i] <= d_new[i];
                    end
                end
                S_ENERGY: begin
                    k_q <= last_step ? 3'd0 : k_q + 3'd1;
                    if (last_step) e_q <= mac_sum[AW-1:FRAC];
                end
                S_CHECK: begin
                    below_q <= !(e_q > energy_thr);
                    t_q     <= '0;
                    chi_q   <= '0;
                end
                S_TIMING: begin
                    k_q <= last_step ? 3'd0 : k_q + 3'd1;
                    if (last_step) t_q <= mac_sum[AW-1:FRAC];
                end
                S_QSHAPE: r_q <= sat_op(resid_w);
                S_QSQUARE: begin
                    k_q <= last_step ? 3'd0 : k_q + 3'd1;
                    if (last_step) chi_q <= mac_sum;
                end
                S_FINISH: begin
                    res_valid  <= 1'b1;
                    res_chan   <= chan_q;
                    res_energy <= e_q;
                    res_timing <= t_q;
                    res_chi    <= chi_q;
                    res_below  <= below_q;
                end
                default: ;
            endcase
        end
    end

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready) |=> !ev_ready);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R3
    below_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_below) |-> (res_timing == '0 && res_chi == '0));

    // R5
    chi_sign_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !res_chi[AW-1]);

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> $stable(cset_q));

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        k_q <= LAST);

endmodule

// File: rtl/ofc_energy_unit.sv
module ofc_energy_unit
    import ofc_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int SW   = 16,
    parameter int FRAC = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int EW  = AW - FRAC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CHW-1:0]        cfg_chan,
    input  logic [SELW-1:0]       cfg_sel,
    input  logic [MW-1:0]         cfg_data,
    input  logic signed [EW-1:0]  energy_thr,
    input  logic                  ev_valid,
    output logic                  ev_ready,
    input  logic [CHW-1:0]        ev_chan,
    input  logic [NSAMP*SW-1:0]   ev_samples,
    input  logic [SW-1:0]         ev_ped,
    output logic                  res_valid,
    output logic [CHW-1:0]        res_chan,
    output logic signed [EW-1:0]  res_energy,
    output logic signed [EW-1:0]  res_timing,
    output logic [AW-1:0]         res_chi,
    output logic                  res_below
);

    logic [NCOEF*MW-1:0]  coef_row;
    logic signed [PW-1:0] mac_prod;
    logic signed [AW-1:0] mac_sum;
    logic                 mac_clr;
    logic                 mac_en;
    op_t                  mac_x;
    op_t                  mac_y;

    ofc_coef_bank #(
        .NCH (NCH),
        .CHW (CHW)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_chan (cfg_chan),
        .wr_sel  (cfg_sel),
        .wr_data (op_t'(cfg_data)),
        .rd_chan (ev_chan),
        .rd_row  (coef_row)
    );

    ofc_mac u_mac (
        .clk     (clk),
        .rst     (rst),
        .clr     (mac_clr),
        .acc_en  (mac_en),
        .op_x    (mac_x),
        .op_y    (mac_y),
        .prod    (mac_prod),
        .sum_nxt (mac_sum)
    );

    ofc_seq #(
        .SW   (SW),
        .FRAC (FRAC),
        .CHW  (CHW),
        .EW   (EW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev_valid   (ev_valid),
        .ev_chan    (ev_chan),
        .ev_samples (ev_samples),
        .ev_ped     (ev_ped),
        .energy_thr (energy_thr),
        .coef_row   (coef_row),
        .mac_prod   (mac_prod),
        .mac_sum    (mac_sum),
        .mac_clr    (mac_clr),
        .mac_en     (mac_en),
        .mac_x      (mac_x),
        .mac_y      (mac_y),
        .ev_ready   (ev_ready),
        .res_valid  (res_valid),
        .res_chan   (res_chan),
        .res_energy (res_energy),
        .res_timing (res_timing),
        .res_chi    (res_chi),
        .res_below  (res_below)
    );

endmodule

// File: tb/tb_ofc_energy_unit.sv
module tb_ofc_energy_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int SW   = 16;
    localparam int FRAC = 8;
    localparam int CHW  = 3;
    localparam int EW   = 31;
    localparam int AW   = 39;
    localparam int LAT_LOW  = 7;
    localparam int LAT_HIGH = 22;
    localparam longint THR = 200;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cfg_we = 1'b0;
    logic [CHW-1:0]       cfg_chan = '0;
    logic [3:0]           cfg_sel = '0;
    logic [17:0]          cfg_data = '0;
    logic signed [EW-1:0] energy_thr = EW'(THR);
    logic                 ev_valid = 1'b0;
    logic                 ev_ready;
    logic [CHW-1:0]       ev_chan = '0;
    logic [5*SW-1:0]      ev_samples = '0;
    logic [SW-1:0]        ev_ped = '0;
    logic                 res_valid;
    logic [CHW-1:0]       res_chan;
    logic signed [EW-1:0] res_energy;
    logic signed [EW-1:0] res_timing;
    logic [AW-1:0]        res_chi;
    logic                 res_below;

    ofc_energy_unit #(.NCH(NCH), .SW(SW), .FRAC(FRAC)) dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .energy_thr(energy_thr),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan),
        .ev_samples(ev_samples), .ev_ped(ev_ped),
        .res_valid(res_valid), .res_chan(res_chan), .res_energy(res_energy),
        .res_timing(res_timing), .res_chi(res_chi), .res_below(res_below)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int     ch;
        longint e;
        longint t;
        longint c;
        bit     below;
        longint t0;
    } exp_t;

    exp_t   sb_q[$];
    longint shadow [NCH][15];
    longint cyc = 0;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     prev_valid = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat18(input longint v);
        if (v > 131071) return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    // independent model of the requirements R2..R5
    function automatic exp_t model(input int ch, input int s [5], input int ped);
        exp_t   x;
        longint d [5];
        longint acc;
        longint es;
        longint r;
        x.ch = ch;
        acc = 0;
        for (int i = 0; i < 5; i++) begin
            d[i] = sat18(longint'(s[i]) - longint'(ped));
            acc += shadow[ch][i] * d[i];
        end
        x.e = acc >>> FRAC;
        x.below = !(x.e > THR);
        x.t = 0;
        x.c = 0;
        if (!x.below) begin
            acc = 0;
            for (int i = 0; i < 5; i++) acc += shadow[ch][5+i] * d[i];
            x.t = acc >>> FRAC;
            es = sat18(x.e);
            for (int i = 0; i < 5; i++) begin
                r = sat18(d[i] - ((es * shadow[ch][10+i]) >>> FRAC));
                x.c += r * r;
            end
        end
        x.t0 = 0;
        return x;
    endfunction

    task automatic cfg_write(input int ch, input int sel, input int val);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_chan = CHW'(ch);
        cfg_sel  = 4'(sel);
        cfg_data = 18'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 15) shadow[ch][sel] = longint'(val);
    endtask

    task automatic load_set(input int ch, input int a [5], input int b [5], input int g [5]);
        for (int i = 0; i < 5; i++) begin
            cfg_write(ch, i, a[i]);
            cfg_write(ch, 5 + i, b[i]);
            cfg_write(ch, 10 + i, g[i]);
        end
    endtask

    task automatic send_event(input int ch, input int s [5], input int ped);
        exp_t x;
        @(negedge clk);
        while (!ev_ready) @(negedge clk);
        ev_valid = 1'b1;
        ev_chan  = CHW'(ch);
        ev_ped   = SW'(ped);
        for (int i = 0; i < 5; i++) ev_samples[i*SW +: SW] = SW'(s[i]);
        x = model(ch, s, ped);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        x.t0 = cyc;
        sb_q.push_back(x);
        // R8: busy right after acceptance
        chk("R8", "ev_ready after accept", longint'(ev_ready), 0);
    endtask

    // monitor: compares each result against the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                chk("R9", "consecutive valid", longint'(prev_valid), 0);
                if (sb_q.size() == 0) begin
                    chk("R9", "unexpected result", 1, 0);
                end else begin
                    exp_t x;
                    x = sb_q.pop_front();
                    chk("R6", "res_chan", longint'(res_chan), longint'(x.ch));
                    chk("R2", "res_energy", longint'(res_energy), x.e);
                    chk("R3", "res_below", longint'(res_below), longint'(x.below));
                    chk("R4", "res_timing", longint'(res_timing), x.t);
                    chk("R5", "res_chi", longint'(res_chi), x.c);
                    chk("R8", "latency", cyc - x.t0, x.below ? LAT_LOW : LAT_HIGH);
                end
            end
            prev_valid = res_valid;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, run hung");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int j = 0; j < 15; j++) shadow[c][j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ev_ready after reset", longint'(ev_ready), 1);
        chk("R1", "res_valid after reset", longint'(res_valid), 0);

        // R1: unwritten channel has zero coefficients, so energy 0 and below
        send_event(2, '{900, 1200, 1500, 800, 400}, 10);

        load_set(0, '{12, 52, 128, 52, 12}, '{-30, -90, 0, 90, 30}, '{40, 150, 256, 150, 40});
        load_set(3, '{-8, 60, 140, 60, -8}, '{10, -70, 5, 70, -10}, '{30, 120, 256, 170, 60});
        load_set(5, '{256, 256, 256, 256, 256}, '{0, 0, 0, 0, 0},
                 '{131071, 131071, 131071, 131071, 131071});
        load_set(7, '{256, 0, 0, 0, 0}, '{0, 0, 256, 0, 0}, '{256, 0, 0, 0, 0});

        // R3 small pulse below threshold
        send_event(0, '{101, 103, 104, 102, 100}, 100);
        // R2 R4 R5 pulse above threshold
        send_event(0, '{150, 600, 1100, 700, 200}, 100);
        // R6 a different channel with a negative pedestal
        send_event(3, '{-40, 300, 900, 500, 20}, -50);
        // R2 negative energy
        send_event(0, '{100, 0, -200, 0, 100}, 500);
        // R5 energy operand and residual clamp
        send_event(5, '{30000, 30000, 30000, 30000, 30000}, -30000);
        // R2 extreme samples with clamped correction path
        send_event(0, '{-32768, -32768, -32768, -32768, -32768}, 32767);
        // R3 boundary: energy equal to threshold stays below
        send_event(7, '{200, 5, 6, 7, 8}, 0);
        // R3 one above threshold
        send_event(7, '{201, 5, 6, 7, 8}, 0);
        // R6 selector 15 changes nothing
        cfg_write(7, 15, 999);
        send_event(7, '{201, 5, 6, 7, 8}, 0);
        // R7 write during the event is held back to the next event
        send_event(0, '{150, 600, 1100, 700, 200}, 100);
        cfg_write(0, 2, 300);
        send_event(0, '{150, 600, 1100, 700, 200}, 100);

        repeat (40) @(negedge clk);
        chk("R9", "results outstanding", longint'(sb_q.size()), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule